// File: doc/BRIEF.md
# Periodic Interrupt Timer

This block produces a steady stream of interrupt requests for software that has to run work at fixed intervals, for example stepping a scanned display or sampling an input. A prescaler divides the system clock down to a 100 kHz timebase (one tick every 10 µs). Each tick moves an 8-bit down counter one step. When the counter reaches zero, the block latches a triggered flag and reloads the counter from a software-set reload value. The result is a period of reload-value-plus-one ticks. For example, a reload value of 199 gives a 2 ms period.

Software reaches the timer through a small register port with two locations. Location 0 holds the reload value on writes and returns the live count on reads. Location 1 holds the interrupt enable on writes and returns the triggered flag on reads. The port is a plain single-cycle register bus with no back-pressure: an access is acknowledged in the same cycle it is presented, and the interrupt handshake is a level request with a one-cycle acknowledge pulse. No part of this block carries a data stream, so none of its pins use valid/ready.

Top module: `tick_timer`

## Requirements
- R1: The count moves at most once every DIV clock cycles, where DIV = CLK_HZ / TICK_HZ. After a write to location 0, the first move happens at the DIV-th rising edge following the write edge.
- R2: A write to location 0 (bus_adr = 0, bus_cyc = bus_stb = bus_we = 1) stores bus_wdata[7:0] as the reload value and loads it into the count at that same edge. It also restarts the prescaler phase. If a tick falls on that edge, the write takes precedence.
- R3: A read of location 0 returns the current count on bus_rdata[7:0] in the same cycle.
- R4: On a tick, a nonzero count decreases by one, and a zero count is replaced by the reload value, so one period lasts reload + 1 ticks.
- R5: The triggered flag is set at the tick edge where the count becomes zero: from 1, or from 0 when the reload value is 0. A read of location 1 returns the flag in bus_rdata bit 0, with all other bits zero.
- R6: A high irq_ack at an edge clears the flag. If a zero event falls on the same edge, the flag stays set.
- R7: A write to location 1 sets the enable from bus_wdata bit 0. irq_req is high exactly when both the flag and the enable are set.
- R8: bus_ack is high in the same cycle when bus_cyc and bus_stb are both high, and low otherwise. An access with bus_stb low changes nothing. bus_rdata is zero whenever no read is presented.
- R9: Reset (rst high, synchronous) clears the count, the reload value, the enable, the flag and the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cyc | input | 1 | Bus cycle active |
| bus_stb | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_adr | input | 1 | Register location (0 count/reload, 1 enable/flag) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, zero when not reading |
| bus_ack | output | 1 | Same-cycle acknowledge |
| irq_req | output | 1 | Interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge pulse |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is the zero event that sets the flag and the acknowledge that clears it. The bench raises irq_ack exactly at the edge where the count steps from 1 to 0 and expects the flag to read back as set; a lone acknowledge one cycle later must then read it as clear. The second pair is a reload write and a prescaler tick. The bench issues the write on the very edge where a tick is due and expects the count to read back as the new value rather than a decremented one, with the next decrement a full prescaler period later.

// File: rtl/tt_pkg.sv
`timescale 1ns/1ps
package tt_pkg;
  // Register locations on the port bus; the decode depends on these values.
  typedef enum logic {
    LOC_COUNT = 1'b0,
    LOC_CTRL  = 1'b1
  } tt_loc_e;
endpackage

// File: rtl/tt_prescaler.sv
`timescale 1ns/1ps
module tt_prescaler #(
  parameter int CLK_HZ  = 100_000_000,
  parameter int TICK_HZ = 100_000
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  localparam int DIV = (CLK_HZ / TICK_HZ < 1) ? 1 : CLK_HZ / TICK_HZ;

  generate
    if (DIV == 1) begin : g_pass
      assign tick = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] phase_q;

      always_ff @(posedge clk) begin
        if (rst || restart)      phase_q <= '0;
        else if (phase_q == LAST) phase_q <= '0;
        else                     phase_q <= phase_q + PW'(1);
      end

      assign tick = (phase_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/tt_downcounter.sv
`timescale 1ns/1ps
module tt_downcounter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count,
  output logic             zero_evt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic at_zero;
  assign at_zero  = (count == '0);
  // Zero event: this tick leaves the count at zero (write has priority).
  assign zero_evt = tick && !load && (at_zero ? (reload_val == '0) : (count == ONE));

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (load) count <= load_val;
    else if (tick) count <= at_zero ? reload_val : count - ONE;
  end
endmodule

// File: rtl/tt_irqflag.sv
`timescale 1ns/1ps
module tt_irqflag (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic clr_pulse,
  input  logic enable,
  output logic flag,
  output logic req
);
  always_ff @(posedge clk) begin
    if (rst)            flag <= 1'b0;
    else if (set_evt)   flag <= 1'b1;
    else if (clr_pulse) flag <= 1'b0;
  end

  assign req = flag && enable;
endmodule

// File: rtl/tick_timer.sv
`timescale 1ns/1ps
module tick_timer #(
  parameter int CLK_HZ  = 100_000_000,
  parameter int TICK_HZ = 100_000,
  parameter int CNT_W   = 8,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_cyc,
  input  logic              bus_stb,
  input  logic              bus_we,
  input  logic              bus_adr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ack,
  output logic              irq_req,
  input  logic              irq_ack
);
  import tt_pkg::*;

  logic             sel, wr_cnt, wr_ctl, rd_on;
  logic             tick, zero_evt, trig_q, irq_en_q;
  logic [CNT_W-1:0] reload_q, count_q;

  assign sel    = bus_cyc && bus_stb;
  assign wr_cnt = sel && bus_we && (tt_loc_e'(bus_adr) == LOC_COUNT);
  assign wr_ctl = sel && bus_we && (tt_loc_e'(bus_adr) == LOC_CTRL);
  assign rd_on  = sel && !bus_we;
  assign bus_ack = sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '0;
      irq_en_q <= 1'b0;
    end else begin
      if (wr_cnt) reload_q <= bus_wdata[CNT_W-1:0];
      if (wr_ctl) irq_en_q <= bus_wdata[0];
    end
  end

  tt_prescaler #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) u_pre (
    .clk(clk), .rst(rst), .restart(wr_cnt), .tick(tick)
  );

  tt_downcounter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .load(wr_cnt),
    .load_val(bus_wdata[CNT_W-1:0]), .reload_val(reload_q),
    .count(count_q), .zero_evt(zero_evt)
  );

  tt_irqflag u_flag (
    .clk(clk), .rst(rst), .set_evt(zero_evt), .clr_pulse(irq_ack),
    .enable(irq_en_q), .flag(trig_q), .req(irq_req)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_on) begin
      if (tt_loc_e'(bus_adr) == LOC_COUNT) bus_rdata[CNT_W-1:0] = count_q;
      else                                 bus_rdata[0]         = trig_q;
    end
  end
endmodule

// File: rtl/tt_checker.sv
`timescale 1ns/1ps
module tt_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             stb,
  input logic             ack,
  input logic             wr_cnt,
  input logic [CNT_W-1:0] wdata,
  input logic [CNT_W-1:0] count,
  input logic             zero_evt,
  input logic             trig,
  input logic             irq_ack,
  input logic             irq_req
);
  AST_LOAD_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_cnt |=> count == $past(wdata)); // R2
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!wr_cnt && count != '0) |=> (count == $past(count) || count == $past(count) - CNT_W'(1))); // R4
  AST_FLAG_RISES_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(trig) |-> count == '0); // R5
  AST_FLAG_FALLS_ON_ACK: assert property (@(posedge clk) disable iff (rst)
    $fell(trig) |-> $past(irq_ack)); // R6
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (zero_evt && irq_ack) |=> trig); // R6
  AST_REQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> trig); // R7
  AST_NO_ACK_WITHOUT_STB: assert property (@(posedge clk) disable iff (rst)
    !stb |-> !ack); // R8
  AST_RESET_IDLE: assert property (@(posedge clk)
    $fell(rst) |-> (count == '0 && !trig && !irq_req)); // R9
endmodule

bind tick_timer tt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .stb(bus_stb), .ack(bus_ack), .wr_cnt(wr_cnt),
  .wdata(bus_wdata[CNT_W-1:0]), .count(count_q), .zero_evt(zero_evt),
  .trig(trig_q), .irq_ack(irq_ack), .irq_req(irq_req)
);

// File: tb/tb_tick_timer.sv
`timescale 1ns/1ps
module tb_tick_timer;
  logic       clk = 1'b0, rst = 1'b1;
  logic       bus_cyc = 0, bus_stb = 0, bus_we = 0, bus_adr = 0, irq_ack = 0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       bus_ack, irq_req;
  int checks = 0, failures = 0;
  bit done = 0;

  // DIV = 4 clock cycles per tick
  tick_timer #(.CLK_HZ(400_000), .TICK_HZ(100_000)) dut (
    .clk(clk), .rst(rst), .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we),
    .bus_adr(bus_adr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .irq_req(irq_req), .irq_ack(irq_ack)
  );

  always #5 clk = ~clk;

  // reload, cycles after write, expected count, expected flag
  localparam int NV = 13;
  localparam int VEC [NV][4] = '{
    '{5, 0, 5, 0}, '{5, 3, 5, 0}, '{5, 4, 4, 0}, '{5, 19, 1, 0},
    '{5, 20, 0, 1}, '{5, 23, 0, 1}, '{5, 24, 5, 1}, '{5, 44, 0, 1},
    '{3, 17, 3, 1}, '{0, 2, 0, 0}, '{0, 4, 0, 1}, '{255, 8, 253, 0},
    '{200, 40, 190, 0}
  };

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic adr, input logic [7:0] d, input logic ack);
    bus_cyc = 1; bus_stb = 1; bus_we = 1; bus_adr = adr; bus_wdata = d; irq_ack = ack;
    @(posedge clk);
    @(negedge clk);
    bus_cyc = 0; bus_stb = 0; bus_we = 0; bus_wdata = '0; irq_ack = 0;
  endtask

  task automatic bus_read(input logic adr, output logic [7:0] d, output logic a);
    bus_cyc = 1; bus_stb = 1; bus_we = 0; bus_adr = adr;
    #1;
    d = bus_rdata; a = bus_ack;
    bus_cyc = 0; bus_stb = 0;
    #1;
  endtask

  initial begin
    logic [7:0] d;
    logic a;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R9: reset state
    bus_read(0, d, a); check("R9 count after reset", d, 0);
    check("R8 ack on read", a, 1);
    bus_read(1, d, a); check("R9 flag after reset", d, 0);
    check("R9 irq_req after reset", irq_req, 0);
    check("R8 rdata idle zero", bus_rdata, 0);

    bus_write(1, 8'h01, 0);
    for (int i = 0; i < NV; i++) begin
      bus_write(0, 8'(VEC[i][0]), 1);
      repeat (VEC[i][1]) @(negedge clk);
      bus_read(0, d, a); check($sformatf("R4 R1 count vec%0d", i), d, VEC[i][2]);
      bus_read(1, d, a); check($sformatf("R5 flag vec%0d", i), d, VEC[i][3]);
      check($sformatf("R7 irq_req vec%0d", i), irq_req, VEC[i][3]);
    end

    // R8: write with strobe low is ignored
    bus_write(0, 8'd10, 1);
    bus_cyc = 1; bus_stb = 0; bus_we = 1; bus_adr = 0; bus_wdata = 8'd77;
    #1; check("R8 no ack without stb", bus_ack, 0);
    @(negedge clk);
    bus_cyc = 0; bus_we = 0; bus_wdata = '0;
    bus_read(0, d, a); check("R8 stb-low write ignored", d, 10);

    // R6: zero event and acknowledge on the same edge
    bus_write(0, 8'd2, 1);
    repeat (7) @(negedge clk);
    irq_ack = 1;
    @(negedge clk);
    irq_ack = 0;
    bus_read(1, d, a); check("R6 set wins over ack", d, 1);
    bus_read(0, d, a); check("R4 count at zero", d, 0);
    irq_ack = 1;
    @(negedge clk);
    irq_ack = 0;
    bus_read(1, d, a); check("R6 ack clears flag", d, 0);
    repeat (11) @(negedge clk);
    bus_read(1, d, a); check("R5 second period flag", d, 1);
    check("R7 irq_req enabled", irq_req, 1);
    bus_write(1, 8'h00, 0);
    check("R7 irq_req masked", irq_req, 0);
    bus_read(1, d, a); check("R5 R7 flag kept while masked", d, 1);

    // R2: write lands on a tick edge
    bus_write(0, 8'd5, 1);
    repeat (3) @(negedge clk);
    bus_write(0, 8'd9, 0);
    bus_read(0, d, a); check("R2 write beats tick", d, 9);
    repeat (3) @(negedge clk);
    bus_read(0, d, a); check("R1 no move before DIV", d, 9);
    @(negedge clk);
    bus_read(0, d, a); check("R1 R3 move after DIV", d, 8);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule